// File: doc/BRIEF.md
# Multi-Device Sync Pulse Issuer

This block runs on the host side of a group of devices that must be aligned to one another. On a start request it first waits until every device says it is ready. Devices may become ready at different times. Then it drives one shared pulse line, so that all devices see the same edges, with a fixed train of six pulses. The pulse width and the low gap between pulses are programmable cycle counts.

After the last pulse the issuer watches the per-device done bits. If every device confirms completion inside a programmable window, it raises a success flag. If one device does not confirm, it counts a retry and starts again from the readiness check. When the programmed retry limit is used up, or the readiness wait runs too long, it raises a failure flag instead.

The ready and done vectors come from other clock domains, so each passes through a two-stage synchronizer before it is used. All settings are captured at the start request and held for the whole run.

Top module: `sync_pulse_issuer`

## Requirements
- R1: While reset is asserted and after it is released, pulse_o, busy_o, success_o and fail_o are 0 and retry_cnt_o is 0.
- R2: Each bit of dev_ready_i and dev_done_i passes through two flip-flops before use, so a change sampled at clock edge k is acted on at edge k+2. No pulse starts until all N_DEV synchronized ready bits are 1 at the same time.
- R3: One train is exactly six high periods on pulse_o. Each high period lasts width_i cycles, and each pair of high periods is separated by gap_i low cycles. A value of 0 for either setting is treated as 1.
- R4: width_i, gap_i, ready_tmo_i, done_tmo_i and max_retry_i are captured on the cycle start_i is accepted. Later changes have no effect on the run in progress.
- R5: After the sixth high period ends, the issuer checks the synchronized done bits each cycle for up to done_tmo_i+1 cycles. If all of them are 1, success_o is set to 1 and the block returns to idle.
- R6: If the done window expires with a bit still 0 and retry_cnt_o is below max_retry_i, retry_cnt_o increments by 1 and the whole sequence restarts from the readiness check.
- R7: If the done window expires with retry_cnt_o equal to max_retry_i, fail_o is set to 1 and the block returns to idle. success_o and fail_o are never 1 together.
- R8: If the synchronized ready bits are not all 1 within ready_tmo_i+1 cycles of the readiness check, fail_o is set to 1 and the block returns to idle.
- R9: start_i is accepted only when idle. busy_o is 1 from the cycle after acceptance until the return to idle. A start_i while busy is ignored.
- R10: An accepted start clears success_o, fail_o and retry_cnt_o. Between runs all three hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a synchronization run |
| dev_ready_i | input | N_DEV | Per-device readiness, asynchronous |
| dev_done_i | input | N_DEV | Per-device completion, asynchronous |
| width_i | input | CNT_W | Pulse high time in cycles |
| gap_i | input | CNT_W | Low time between pulses in cycles |
| ready_tmo_i | input | CNT_W | Readiness wait limit in cycles |
| done_tmo_i | input | CNT_W | Completion wait limit in cycles |
| max_retry_i | input | RETRY_W | Number of restarts allowed |
| pulse_o | output | 1 | Shared pulse line to all devices |
| busy_o | output | 1 | A run is in progress |
| success_o | output | 1 | Last run finished with all devices done |
| fail_o | output | 1 | Last run timed out or used up its retries |
| retry_cnt_o | output | RETRY_W | Restarts made in the current or last run |

## Verification
The assertions assume that dev_done_i and dev_ready_i settle to one value per clock period, so the bit sampled three edges before a success matches what the synchronizer carried. They also assume that the settings may change at any time, and they never depend on those settings outside the captured copies. The stimulus changes every input only on the falling clock edge. It raises the ready bits one device at a time and withholds a done bit to force retries. It also rewrites the settings and pulses start_i in the middle of a run, so the capture and ignore rules are tested.

// File: rtl/sip_pkg.sv
package sip_pkg;
    localparam int unsigned PULSES = 6;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_DONE  = 3'd4
    } sip_state_e;
endpackage

// File: rtl/sip_sync2.sv
module sip_sync2 #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                meta_q <= async_i[b];
                hold_q <= meta_q;
            end
        end
        assign sync_o[b] = hold_q;
    end
endmodule

// File: rtl/sip_seq.sv
module sip_seq
    import sip_pkg::*;
#(
    parameter int unsigned N_DEV   = 4,
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [N_DEV-1:0]   ready_s_i,
    input  logic [N_DEV-1:0]   done_s_i,
    input  logic [CNT_W-1:0]   width_i,
    input  logic [CNT_W-1:0]   gap_i,
    input  logic [CNT_W-1:0]   ready_tmo_i,
    input  logic [CNT_W-1:0]   done_tmo_i,
    input  logic [RETRY_W-1:0] max_retry_i,
    output logic               pulse_o,
    output logic               busy_o,
    output logic               success_o,
    output logic               fail_o,
    output logic [RETRY_W-1:0] retry_cnt_o
);
    localparam int unsigned IDX_W = $clog2(PULSES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PULSES - 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        sip_state_e         state;
        logic [CNT_W-1:0]   tmr;
        logic [IDX_W-1:0]   idx;
        logic [RETRY_W-1:0] retries;
        logic [CNT_W-1:0]   width;
        logic [CNT_W-1:0]   gap;
        logic [CNT_W-1:0]   rdy_tmo;
        logic [CNT_W-1:0]   dn_tmo;
        logic [RETRY_W-1:0] max_retry;
        logic               succ;
        logic               fail;
    } seq_t;

    seq_t seq_d, seq_q;

    logic all_ready, all_done;
    assign all_ready = &ready_s_i;
    assign all_done  = &done_s_i;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.width     = (width_i == '0) ? ONE : width_i;
                    seq_d.gap       = (gap_i == '0) ? ONE : gap_i;
                    seq_d.rdy_tmo   = ready_tmo_i;
                    seq_d.dn_tmo    = done_tmo_i;
                    seq_d.max_retry = max_retry_i;
                    seq_d.retries   = '0;
                    seq_d.succ      = 1'b0;
                    seq_d.fail      = 1'b0;
                    seq_d.tmr       = '0;
                    seq_d.state     = ST_READY;
                end
            end
            ST_READY: begin
                if (all_ready) begin
                    seq_d.tmr   = '0;
                    seq_d.idx   = '0;
                    seq_d.state = ST_HIGH;
                end else if (seq_q.tmr == seq_q.rdy_tmo) begin
                    seq_d.fail  = 1'b1;
                    seq_d.state = ST_IDLE;
                end else begin
                    seq_d.tmr = seq_q.tmr + ONE;
                end
            end
            ST_HIGH: begin
                if (seq_q.tmr == seq_q.width - ONE) begin
                    seq_d.tmr = '0;
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.state = ST_DONE;
                    end else begin
                        seq_d.idx   = seq_q.idx + IDX_W'(1);
                        seq_d.state = ST_LOW;
                    end
                end else begin
                    seq_d.tmr = seq_q.tmr + ONE;
                end
            end
            ST_LOW: begin
                if (seq_q.tmr == seq_q.gap - ONE) begin
                    seq_d.tmr   = '0;
                    seq_d.state = ST_HIGH;
                end else begin
                    seq_d.tmr = seq_q.tmr + ONE;
                end
            end
            ST_DONE: begin
                if (all_done) begin
                    seq_d.succ  = 1'b1;
                    seq_d.state = ST_IDLE;
                end else if (seq_q.tmr == seq_q.dn_tmo) begin
                    if (seq_q.retries == seq_q.max_retry) begin
                        seq_d.fail  = 1'b1;
                        seq_d.state = ST_IDLE;
                    end else begin
                        seq_d.retries = seq_q.retries + RETRY_W'(1);
                        seq_d.tmr     = '0;
                        seq_d.state   = ST_READY;
                    end
                end else begin
                    seq_d.tmr = seq_q.tmr + ONE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pulse_o     = (seq_q.state == ST_HIGH);
    assign busy_o      = (seq_q.state != ST_IDLE);
    assign success_o   = seq_q.succ;
    assign fail_o      = seq_q.fail;
    assign retry_cnt_o = seq_q.retries;
endmodule

// File: rtl/sync_pulse_issuer.sv
module sync_pulse_issuer #(
    parameter int unsigned N_DEV   = 4,
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [N_DEV-1:0]   dev_ready_i,
    input  logic [N_DEV-1:0]   dev_done_i,
    input  logic [CNT_W-1:0]   width_i,
    input  logic [CNT_W-1:0]   gap_i,
    input  logic [CNT_W-1:0]   ready_tmo_i,
    input  logic [CNT_W-1:0]   done_tmo_i,
    input  logic [RETRY_W-1:0] max_retry_i,
    output logic               pulse_o,
    output logic               busy_o,
    output logic               success_o,
    output logic               fail_o,
    output logic [RETRY_W-1:0] retry_cnt_o
);
    logic [N_DEV-1:0] ready_s, done_s;

    sip_sync2 #(.W(N_DEV)) u_sync_ready (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(dev_ready_i),
        .sync_o (ready_s)
    );

    sip_sync2 #(.W(N_DEV)) u_sync_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(dev_done_i),
        .sync_o (done_s)
    );

    sip_seq #(.N_DEV(N_DEV), .CNT_W(CNT_W), .RETRY_W(RETRY_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ready_s_i  (ready_s),
        .done_s_i   (done_s),
        .width_i    (width_i),
        .gap_i      (gap_i),
        .ready_tmo_i(ready_tmo_i),
        .done_tmo_i (done_tmo_i),
        .max_retry_i(max_retry_i),
        .pulse_o    (pulse_o),
        .busy_o     (busy_o),
        .success_o  (success_o),
        .fail_o     (fail_o),
        .retry_cnt_o(retry_cnt_o)
    );
endmodule

// File: rtl/sip_checker.sv
module sip_checker #(
    parameter int unsigned N_DEV   = 4,
    parameter int unsigned RETRY_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [N_DEV-1:0]   dev_done_i,
    input logic               pulse_o,
    input logic               busy_o,
    input logic               success_o,
    input logic               fail_o,
    input logic [RETRY_W-1:0] retry_cnt_o
);
    // R3: the shared line is driven only inside a run
    a_r3_pulse_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> busy_o);

    // R7: outcome flags exclusive
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(success_o && fail_o));

    // R5: success only after all done bits crossed the two-stage synchronizer
    a_r5_success_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(success_o) |-> ($past(&dev_done_i, 3) && !busy_o));

    // R8: a failure is raised only on the way back to idle
    a_r8_fail_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (!busy_o && $past(busy_o)));

    // R6: during a run the retry count only steps up by one
    a_r6_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
            (retry_cnt_o == $past(retry_cnt_o) ||
             retry_cnt_o == $past(retry_cnt_o) + RETRY_W'(1)));

    // R10: results hold while idle without a start
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=>
            ($stable(success_o) && $stable(fail_o) && $stable(retry_cnt_o)));
endmodule

bind sync_pulse_issuer sip_checker #(.N_DEV(N_DEV), .RETRY_W(RETRY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dev_done_i (dev_done_i),
    .pulse_o    (pulse_o),
    .busy_o     (busy_o),
    .success_o  (success_o),
    .fail_o     (fail_o),
    .retry_cnt_o(retry_cnt_o)
);

// File: tb/tb_sync_pulse_issuer.sv
module tb_sync_pulse_issuer;
    localparam int N = 4;
    localparam int CW = 12;
    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [N-1:0] ready_i = '0, done_i = '0;
    logic [CW-1:0] width_i = 12'd1, gap_i = 12'd1, rto_i = 12'd20, dto_i = 12'd10;
    logic [RW-1:0] mr_i = '0;
    logic pulse_o, busy_o, success_o, fail_o;
    logic [RW-1:0] retry_o;

    always #4 clk = ~clk;

    sync_pulse_issuer #(.N_DEV(N), .CNT_W(CW), .RETRY_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dev_ready_i(ready_i), .dev_done_i(done_i),
        .width_i(width_i), .gap_i(gap_i), .ready_tmo_i(rto_i), .done_tmo_i(dto_i),
        .max_retry_i(mr_i), .pulse_o(pulse_o), .busy_o(busy_o),
        .success_o(success_o), .fail_o(fail_o), .retry_cnt_o(retry_o)
    );

    // Behavioural reference: integers plus two-deep input history per vector
    int m_st = 0;  // 0 idle, 1 wait ready, 2 high, 3 low, 4 wait done
    int m_tmr = 0, m_idx = 0, m_ret = 0;
    int m_w = 1, m_g = 1, m_rto = 0, m_dto = 0, m_mr = 0;
    bit m_succ = 0, m_fail = 0;
    logic [N-1:0] rh[$], dh[$];
    initial begin
        rh = '{'0, '0};
        dh = '{'0, '0};
    end

    always @(posedge clk) begin
        logic [N-1:0] rs, ds;
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_idx = 0; m_ret = 0; m_succ = 0; m_fail = 0;
            rh = '{'0, '0};
            dh = '{'0, '0};
        end else begin
            rs = rh.pop_front();
            ds = dh.pop_front();
            rh.push_back(ready_i);
            dh.push_back(done_i);
            case (m_st)
                0: if (start_i) begin
                    m_w = (width_i == 0) ? 1 : int'(width_i);
                    m_g = (gap_i == 0) ? 1 : int'(gap_i);
                    m_rto = int'(rto_i); m_dto = int'(dto_i); m_mr = int'(mr_i);
                    m_ret = 0; m_succ = 0; m_fail = 0; m_tmr = 0; m_st = 1;
                end
                1: if (rs == {N{1'b1}}) begin m_st = 2; m_tmr = 0; m_idx = 0; end
                   else if (m_tmr == m_rto) begin m_fail = 1; m_st = 0; end
                   else m_tmr++;
                2: if (m_tmr + 1 >= m_w) begin
                       m_tmr = 0;
                       if (m_idx == 5) m_st = 4; else begin m_idx++; m_st = 3; end
                   end else m_tmr++;
                3: if (m_tmr + 1 >= m_g) begin m_tmr = 0; m_st = 2; end
                   else m_tmr++;
                4: if (ds == {N{1'b1}}) begin m_succ = 1; m_st = 0; end
                   else if (m_tmr == m_dto) begin
                       if (m_ret == m_mr) begin m_fail = 1; m_st = 0; end
                       else begin m_ret++; m_st = 1; m_tmr = 0; end
                   end else m_tmr++;
                default: m_st = 0;
            endcase
        end
    end

    int vectors = 0, miscompares = 0;
    string tag = "R1";

    always @(negedge clk) begin
        bit bad;
        bad = 0;
        vectors++;
        if (pulse_o !== (m_st == 2)) begin
            bad = 1;
            $display("FAIL %s/R3 pulse_o actual=%b expected=%b t=%0t", tag, pulse_o, m_st == 2, $time);
        end
        if (busy_o !== (m_st != 0)) begin
            bad = 1;
            $display("FAIL %s/R9 busy_o actual=%b expected=%b t=%0t", tag, busy_o, m_st != 0, $time);
        end
        if (success_o !== m_succ) begin
            bad = 1;
            $display("FAIL %s/R5 success_o actual=%b expected=%b t=%0t", tag, success_o, m_succ, $time);
        end
        if (fail_o !== m_fail) begin
            bad = 1;
            $display("FAIL %s/R7 fail_o actual=%b expected=%b t=%0t", tag, fail_o, m_fail, $time);
        end
        if (int'(retry_o) !== m_ret) begin
            bad = 1;
            $display("FAIL %s/R6 retry_cnt_o actual=%0d expected=%0d t=%0t", tag, retry_o, m_ret, $time);
        end
        if (bad) miscompares++;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic kick();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_falls(input int n);
        int seen = 0;
        logic prev = pulse_o;
        for (int i = 0; i < 5000 && seen < n; i++) begin
            @(negedge clk);
            if (prev && !pulse_o) seen++;
            prev = pulse_o;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
    endtask

    task automatic settle();
        ready_i = '0;
        done_i = '0;
        cycles(4);
    endtask

    task automatic setup(input int w, input int g, input int rto, input int dto, input int mr);
        width_i = CW'(w); gap_i = CW'(g); rto_i = CW'(rto); dto_i = CW'(dto); mr_i = RW'(mr);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        cycles(3);
        rst_n = 1'b1;
        cycles(3);

        // R2, R3, R5: staggered readiness, then all done
        tag = "R2";
        setup(2, 3, 40, 20, 2);
        kick();
        for (int d = 0; d < N; d++) begin
            cycles(3);
            ready_i[d] = 1'b1;
        end
        tag = "R3";
        wait_falls(6);
        tag = "R5";
        cycles(4);
        done_i = '1;
        wait_idle();
        cycles(2);
        settle();

        // R3: zero width and gap clamp to one
        tag = "R3";
        setup(0, 0, 10, 12, 0);
        ready_i = '1;
        kick();
        wait_falls(6);
        done_i = '1;
        wait_idle();
        settle();

        // R6: one device misses done, retry then succeed
        tag = "R6";
        setup(3, 2, 30, 8, 3);
        ready_i = '1;
        kick();
        wait_falls(6);
        done_i = 4'b0111;
        wait_falls(6);
        done_i = '1;
        wait_idle();
        cycles(2);
        settle();

        // R7: retries used up
        tag = "R7";
        setup(1, 2, 30, 5, 1);
        ready_i = '1;
        done_i = 4'b1011;
        kick();
        wait_idle();
        cycles(3);
        settle();

        // R8: readiness timeout
        tag = "R8";
        setup(2, 2, 15, 5, 0);
        ready_i = 4'b0111;
        kick();
        wait_idle();
        cycles(3);
        settle();

        // R4, R9: settings and start changed mid run are ignored
        tag = "R4";
        setup(4, 5, 30, 20, 0);
        ready_i = '1;
        kick();
        cycles(6);
        setup(1, 1, 0, 0, 0);
        tag = "R9";
        kick();
        wait_falls(6);
        setup(7, 7, 7, 7, 7);
        done_i = '1;
        wait_idle();
        cycles(2);
        settle();

        // R10: a new start clears the previous outcome
        tag = "R10";
        setup(2, 2, 6, 6, 0);
        kick();
        cycles(3);
        ready_i = '1;
        wait_falls(6);
        done_i = '1;
        wait_idle();
        cycles(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog expired actual=busy expected=idle");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule